// File: doc/BRIEF.md
# Protected Configuration Register with Unlock Sequencer

This block is the single configuration and status register of a device that sits behind a two-wire serial slave front end. The front end has already turned line activity into byte events: frame start, device address byte, register pointer byte, data byte and frame end. The block takes those events over a valid/ready stream, decides the acknowledge for each addressed byte, and keeps the register contents. A change to the persistent fields is allowed only after two enable bits have been set in strict order by separate frames. A third frame then commits, and the commit occupies a timed busy window. The persistent storage is modelled as flops.

The register also serves single-byte reads at pointer FFh and drives two permission flags for an adjustable resistor array: one for temporary writes and one for persistent writes. A hardware protect input and a lock field gate these flags. Writes to the register arrive one event per handshake. A read result leaves on a second valid/ready stream. While a read byte is waiting, the event input is back-pressured, and `ev_ready` stays low until the read byte has been taken. A read byte, once presented, holds both its valid and its value until `rd_ready` is seen high on a clock edge.

Top module: `prs_ctrl`

## Requirements
- R1: After reset, `cfg_o` is 00h, `busy_o` is 0, `rd_valid` is 0 and both resistor permission flags are 0.
- R2: Register bits are {delay1[7], monA[6], monB[5], spare[4], lock[3], regwen[2], wen[1], delay0[0]}. A single data byte to pointer FFh is applied at frame end as follows. If bits 2:1 are 01 and regwen is 0, wen is set. If bits 2:1 are 11 and wen is 1, regwen is set; with wen at 0 this byte changes nothing. If bits 2:1 are 00, both enables are cleared. regwen is never 1 while wen is 0.
- R3: A byte with bits 2:1 = 01, sent while regwen is 1 and protect is low, starts a commit. `busy_o` is high for exactly COMMIT_CYC cycles. At the end of the window, bits 7,6,5,3,0 load from the byte, regwen clears and wen stays set. The order 02h, 06h, 02h therefore clears every persistent bit.
- R4: A byte with bits 2:1 = 11 while regwen is 1 keeps regwen set and leaves the persistent bits unchanged.
- R5: A second data byte in one write frame is not acknowledged, and the whole frame is discarded.
- R6: While `protect_i` is high, a commit byte clears regwen, leaves the persistent bits unchanged and does not raise `busy_o`. Enable-bit writes still take effect.
- R7: `res_vol_ok` is wen AND NOT lock. `res_nv_ok` is additionally gated by NOT `protect_i`.
- R8: A device address byte with bit 0 = 1 and pointer FFh is acknowledged, and it returns exactly one byte on `rd_valid`/`rd_data`. Bit 4 of that byte is 0. A read with any other pointer is not acknowledged.
- R9: A read leaves wen and regwen unchanged.
- R10: A frame end between unlock steps keeps the enables. A data byte written to a pointer other than FFh is acknowledged but changes nothing.
- R11: While `busy_o` is high, a device address byte is not acknowledged.
- R12: Each accepted device address, pointer or data byte yields one `resp_valid` pulse in the following cycle. `resp_ack` is 1 for acknowledge. A device address whose bits 7:1 differ from DEV_ID (1010010b by default) is not acknowledged. `ev_kind` codes are 0 start, 1 device address, 2 pointer, 3 data, 4 end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Byte event present |
| ev_ready | output | 1 | Event can be taken (low while a read byte waits) |
| ev_kind | input | 3 | Event code |
| ev_byte | input | 8 | Byte carried by the event |
| protect_i | input | 1 | Hardware write-protect level |
| resp_valid | output | 1 | Acknowledge decision present |
| resp_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| cfg_o | output | 8 | Live register fields |
| busy_o | output | 1 | Commit window in progress |
| res_vol_ok | output | 1 | Temporary resistor write permitted |
| res_nv_ok | output | 1 | Persistent resistor write permitted |

## Verification
The assertions assume that the front end delivers events in legal frame order and that `rst_n` is low before the first clock edge. They also assume that `protect_i` only moves when no frame is ending. The bench's frame tasks always emit start, address, pointer, data and end in that order. The bench wait for `ev_ready` before each event, and it changes `protect_i` only between frames. Both read-stream assertions rely on the consumer being free to stall. The bench holds `rd_ready` low for several cycles before taking each byte.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_DEV   = 3'd1,
    EV_REG   = 3'd2,
    EV_DATA  = 3'd3,
    EV_STOP  = 3'd4
  } ev_kind_e;

  localparam int unsigned BIT_LOCK  = 3;
  localparam int unsigned BIT_RWEN  = 2;
  localparam int unsigned BIT_WEN   = 1;
  localparam int unsigned BIT_SPARE = 4;
  // persistent fields: delay1, monA, monB, lock, delay0
  localparam logic [7:0]  NV_MASK   = 8'hE9;
endpackage

// File: rtl/prs_frame.sv
module prs_frame
  import prs_pkg::*;
#(
  parameter logic [6:0] DEV_ID  = 7'b1010010,
  parameter logic [7:0] SEL_PTR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_i,
  input  ev_kind_e   kind_i,
  input  logic [7:0] byte_i,
  input  logic       busy_i,
  input  logic       rd_done_i,
  output logic       resp_valid_o,
  output logic       resp_ack_o,
  output logic       upd_valid_o,
  output logic [7:0] upd_byte_o,
  output logic       rd_req_o
);
  logic       sel_q, rd_q, have_ptr_q;
  logic [7:0] ptr_q, data_q;
  logic [1:0] ndata_q;
  logic       dev_match, ptr_hit, wr_sel, ack_c;

  assign dev_match = (byte_i[7:1] == DEV_ID) && !busy_i;
  assign ptr_hit   = (ptr_q == SEL_PTR);
  assign wr_sel    = sel_q && !rd_q;

  always_comb begin
    ack_c = 1'b0;
    case (kind_i)
      EV_DEV:  ack_c = dev_match && (!byte_i[0] || ptr_hit);
      EV_REG:  ack_c = wr_sel;
      EV_DATA: ack_c = wr_sel && have_ptr_q && (ndata_q == 2'd0);
      default: ack_c = 1'b0;
    endcase
  end

  // a write frame is applied only when it ends holding exactly one data byte
  assign upd_valid_o = acc_i && (kind_i == EV_STOP) && wr_sel && have_ptr_q
                       && ptr_hit && (ndata_q == 2'd1);
  assign upd_byte_o  = data_q;
  assign rd_req_o    = acc_i && (kind_i == EV_DEV) && dev_match && byte_i[0] && ptr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_ack_o   <= 1'b0;
      sel_q        <= 1'b0;
      rd_q         <= 1'b0;
      have_ptr_q   <= 1'b0;
      ptr_q        <= 8'h00;
      data_q       <= 8'h00;
      ndata_q      <= 2'd0;
    end else begin
      resp_valid_o <= acc_i && (kind_i inside {EV_DEV, EV_REG, EV_DATA});
      resp_ack_o   <= acc_i && ack_c;
      if (rd_done_i) sel_q <= 1'b0;
      if (acc_i) begin
        case (kind_i)
          EV_START: begin
            sel_q      <= 1'b0;
            have_ptr_q <= 1'b0;
            ndata_q    <= 2'd0;
          end
          EV_DEV: begin
            sel_q      <= ack_c;
            rd_q       <= byte_i[0];
            have_ptr_q <= 1'b0;
            ndata_q    <= 2'd0;
          end
          EV_REG: begin
            if (wr_sel) begin
              ptr_q      <= byte_i;
              have_ptr_q <= 1'b1;
            end
          end
          EV_DATA: begin
            if (wr_sel && have_ptr_q) begin
              if (ndata_q == 2'd0) data_q <= byte_i;
              if (ndata_q != 2'd2) ndata_q <= ndata_q + 2'd1;
            end
          end
          default: begin
            sel_q      <= 1'b0;
            have_ptr_q <= 1'b0;
            ndata_q    <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/prs_unlock.sv
module prs_unlock
  import prs_pkg::*;
#(
  parameter int unsigned COMMIT_CYC = 625000,
  localparam int unsigned CW = $clog2(COMMIT_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_valid_i,
  input  logic [7:0] upd_byte_i,
  input  logic       protect_i,
  output logic [7:0] cfg_o,
  output logic       busy_o
);
  logic [7:0]    nv_q, pend_q;
  logic          wen_q, rwen_q, busy_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = busy_q;
  assign cfg_o  = nv_q | {5'b0, rwen_q, wen_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= 8'h00;
      pend_q <= 8'h00;
      wen_q  <= 1'b0;
      rwen_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        nv_q   <= pend_q;
        rwen_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (upd_valid_i) begin
      case (upd_byte_i[BIT_RWEN:BIT_WEN])
        2'b01: begin
          if (!rwen_q) begin
            wen_q <= 1'b1;
          end else if (protect_i) begin
            rwen_q <= 1'b0;
          end else begin
            pend_q <= upd_byte_i & NV_MASK;
            busy_q <= 1'b1;
            cnt_q  <= CW'(COMMIT_CYC - 1);
          end
        end
        2'b11: if (wen_q) rwen_q <= 1'b1;
        2'b00: begin
          wen_q  <= 1'b0;
          rwen_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prs_readout.sv
module prs_readout
  import prs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req_i,
  input  logic [7:0] snap_i,
  input  logic       rd_ready_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       rd_done_o
);
  localparam logic [7:0] SPARE_CLR = ~(8'h01 << BIT_SPARE);

  assign rd_done_o = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= 8'h00;
    end else if (rd_done_o) begin
      rd_valid_o <= 1'b0;
    end else if (rd_req_i && !rd_valid_o) begin
      rd_valid_o <= 1'b1;
      rd_data_o  <= snap_i & SPARE_CLR;
    end
  end
endmodule

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
#(
  parameter logic [6:0]  DEV_ID    = 7'b1010010,
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned COMMIT_US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  input  logic       protect_i,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic [7:0] cfg_o,
  output logic       busy_o,
  output logic       res_vol_ok,
  output logic       res_nv_ok
);
  localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned COMMIT_CYC = (CYC_PER_US * COMMIT_US > 0) ? CYC_PER_US * COMMIT_US : 1;

  logic       acc, upd_valid, rd_req, rd_done;
  logic [7:0] upd_byte;

  assign ev_ready = !rd_valid;
  assign acc      = ev_valid && ev_ready;

  prs_frame #(.DEV_ID(DEV_ID), .SEL_PTR(8'hFF)) u_frame (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .kind_i(ev_kind_e'(ev_kind)),
    .byte_i(ev_byte), .busy_i(busy_o), .rd_done_i(rd_done),
    .resp_valid_o(resp_valid), .resp_ack_o(resp_ack),
    .upd_valid_o(upd_valid), .upd_byte_o(upd_byte), .rd_req_o(rd_req)
  );

  prs_unlock #(.COMMIT_CYC(COMMIT_CYC)) u_unlock (
    .clk(clk), .rst_n(rst_n), .upd_valid_i(upd_valid), .upd_byte_i(upd_byte),
    .protect_i(protect_i), .cfg_o(cfg_o), .busy_o(busy_o)
  );

  prs_readout u_readout (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .snap_i(cfg_o),
    .rd_ready_i(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_done_o(rd_done)
  );

  assign res_vol_ok = cfg_o[BIT_WEN] && !cfg_o[BIT_LOCK];
  assign res_nv_ok  = res_vol_ok && !protect_i;
endmodule

// File: rtl/prs_ctrl_chk.sv
module prs_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [2:0] ev_kind,
  input logic [7:0] ev_byte,
  input logic       protect_i,
  input logic       resp_valid,
  input logic       resp_ack,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [7:0] cfg_o,
  input logic       busy_o,
  input logic       res_vol_ok,
  input logic       res_nv_ok
);
  p_rwen_needs_wen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[2] |-> cfg_o[1]);

  p_nv_at_commit_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_o & 8'hE9) != $past(cfg_o & 8'hE9)) |-> ($past(busy_o) && !busy_o));

  p_no_busy_when_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && protect_i) |=> !busy_o);

  p_res_nv_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_nv_ok |-> (!protect_i && cfg_o[1] && !cfg_o[3]));

  p_spare_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_data[4]);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_backpressure_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !ev_ready);
endmodule

bind prs_ctrl prs_ctrl_chk u_chk (.*);

// File: tb/prs_ctrl_bench.sv
module prs_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0, protect_i = 1'b0, rd_ready = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'h00;
  logic       ev_ready, resp_valid, resp_ack, rd_valid, busy_o, res_vol_ok, res_nv_ok;
  logic [7:0] rd_data, cfg_o;

  always #4 clk = ~clk;

  prs_ctrl #(.CLK_HZ(1_000_000), .COMMIT_US(40)) u_prs_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .protect_i(protect_i),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .cfg_o(cfg_o), .busy_o(busy_o),
    .res_vol_ok(res_vol_ok), .res_nv_ok(res_nv_ok)
  );

  int    n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit    exp_q[$];
  string tag_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every acknowledge decision is popped and compared
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: actual unexpected response expected none");
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, resp_ack, e);
      end
    end
    if (busy_o) busy_cnt++;
  end

  task automatic send(input logic [2:0] k, input logic [7:0] b, input bit ack, input string tag);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    if (k inside {3'd1, 3'd2, 3'd3}) begin
      exp_q.push_back(ack);
      tag_q.push_back(tag);
    end
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic write_frame(input logic [7:0] b, input string tag);
    send(3'd0, 8'h00, 1'b0, tag);
    send(3'd1, 8'hA4, 1'b1, tag);
    send(3'd2, 8'hFF, 1'b1, tag);
    send(3'd3, b,     1'b1, tag);
    send(3'd4, 8'h00, 1'b0, tag);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
  endtask

  task automatic read_reg(input logic [7:0] exp);
    send(3'd0, 8'h00, 1'b0, "R8");
    send(3'd1, 8'hA4, 1'b1, "R8");
    send(3'd2, 8'hFF, 1'b1, "R8");
    send(3'd0, 8'h00, 1'b0, "R8");
    send(3'd1, 8'hA5, 1'b1, "R8");
    check("R8 read valid", rd_valid, 1);
    check("R12 ev_ready low while read byte waits", ev_ready, 0);
    check("R8 read data", rd_data, exp);
    repeat (2) @(negedge clk);
    check("R8 read data held under stall", rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check("R8 single byte then idle", rd_valid, 0);
    send(3'd4, 8'h00, 1'b0, "R8");
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cfg", cfg_o, 8'h00);
    check("R1 busy", busy_o, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 res_vol_ok", res_vol_ok, 0);
    check("R1 res_nv_ok", res_nv_ok, 0);
    rst_n = 1'b1;
    settle();

    write_frame(8'h02, "R2"); settle();
    check("R2 wen set", cfg_o, 8'h02);
    check("R7 vol ok", res_vol_ok, 1);
    check("R7 nv ok", res_nv_ok, 1);
    read_reg(8'h02);
    check("R9 enables kept after read", cfg_o, 8'h02);

    write_frame(8'h06, "R2"); settle();
    check("R10 R2 regwen after separate frame", cfg_o, 8'h06);
    read_reg(8'h06);
    check("R9 regwen kept after read", cfg_o, 8'h06);

    write_frame(8'h06, "R4"); settle();
    check("R4 regwen kept", cfg_o, 8'h06);
    check("R4 no busy", busy_o, 0);

    busy_cnt = 0;
    write_frame(8'hEB, "R3");
    check("R3 busy raised", busy_o, 1);
    send(3'd0, 8'h00, 1'b0, "R11");
    send(3'd1, 8'hA4, 1'b0, "R11");
    send(3'd4, 8'h00, 1'b0, "R11");
    wait_idle();
    check("R3 busy length", busy_cnt, 40);
    settle();
    check("R3 commit loaded", cfg_o, 8'hEB);
    check("R7 lock blocks vol", res_vol_ok, 0);
    read_reg(8'hEB);

    write_frame(8'h06, "R3"); settle();
    check("R3 re-enable", cfg_o, 8'hEF);
    write_frame(8'h02, "R3"); wait_idle(); settle();
    check("R3 clear sequence", cfg_o, 8'h02);
    check("R7 vol ok again", res_vol_ok, 1);

    write_frame(8'h06, "R5"); settle();
    send(3'd0, 8'h00, 1'b0, "R5");
    send(3'd1, 8'hA4, 1'b1, "R5");
    send(3'd2, 8'hFF, 1'b1, "R5");
    send(3'd3, 8'hA3, 1'b1, "R5");
    send(3'd3, 8'h02, 1'b0, "R5");
    send(3'd4, 8'h00, 1'b0, "R5");
    settle();
    check("R5 frame discarded", cfg_o, 8'h06);
    check("R5 no busy", busy_o, 0);

    protect_i = 1'b1;
    @(negedge clk);
    check("R7 protect blocks nv", res_nv_ok, 0);
    write_frame(8'hEB, "R6"); settle();
    check("R6 no busy", busy_o, 0);
    check("R6 regwen cleared nv kept", cfg_o, 8'h02);
    write_frame(8'h06, "R6"); settle();
    check("R6 enable still writable", cfg_o, 8'h06);
    protect_i = 1'b0;

    send(3'd0, 8'h00, 1'b0, "R10");
    send(3'd1, 8'hA4, 1'b1, "R10");
    send(3'd2, 8'h10, 1'b1, "R10");
    send(3'd3, 8'h03, 1'b1, "R10");
    send(3'd4, 8'h00, 1'b0, "R10");
    settle();
    check("R10 other pointer ignored", cfg_o, 8'h06);
    check("R10 no busy", busy_o, 0);
    send(3'd0, 8'h00, 1'b0, "R8");
    send(3'd1, 8'hA4, 1'b1, "R8");
    send(3'd2, 8'h10, 1'b1, "R8");
    send(3'd0, 8'h00, 1'b0, "R8");
    send(3'd1, 8'hA5, 1'b0, "R8");
    send(3'd4, 8'h00, 1'b0, "R8");
    settle();
    check("R8 no byte for other pointer", rd_valid, 0);

    send(3'd0, 8'h00, 1'b0, "R12");
    send(3'd1, 8'hA0, 1'b0, "R12");
    send(3'd2, 8'hFF, 1'b0, "R12");
    send(3'd4, 8'h00, 1'b0, "R12");
    settle();

    write_frame(8'h00, "R2"); settle();
    check("R2 enables cleared", cfg_o, 8'h00);
    write_frame(8'h06, "R2"); settle();
    check("R2 regwen needs wen", cfg_o, 8'h00);
    check("R7 vol off", res_vol_ok, 0);

    settle();
    check("R12 all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule